// File: doc/BRIEF.md
# Mixed Edge/Level Interrupt Aggregator

This block gathers 32 interrupt request lines into one request to a processor. Most lines are treated as edge-type: each line is first synchronised to the block clock, then a rising transition sets a sticky event bit. Software removes these bits by writing ones to a clear register. A fixed group of ten lines, bits 20 to 29, is level-type. Those bits are never latched. Their contribution follows the synchronised state of the line, and the live state of every line can be read from a separate levels register.

Software reaches the block over a simple 32-bit register port with byte addresses. Reads are registered and return data one cycle after the request. A per-source enable register gates both kinds of source. The processor request is registered. It is high whenever an enabled edge event is latched, or whenever an enabled level-type line is currently high.

Top module: `mixed_irq_ctrl`

## Requirements
- R1: After a synchronous reset, the enable register reads 0, the event register reads 0 and `cpu_irq` is 0.
- R2: Bits outside 20..29 are edge-type. A rising edge on `src_i[n]` sets event bit n, and the bit stays set after the line falls. The edge is seen through a two-stage synchroniser, so `cpu_irq` rises on the 4th rising clock edge after the input changes, provided bit n is enabled.
- R3: The event register at offset 0x20 always reads 0 in bits 20..29. The levels register at offset 0x2C returns the synchronised, unlatched state of all 32 lines.
- R4: The enable register at offset 0x24 can be read and written. Bit n enables source n.
- R5: Writing to offset 0x28 clears every event bit whose write-data bit is 1. Event bits whose write-data bit is 0 are left unchanged.
- R6: If a clear of bit n and a newly detected edge on bit n fall in the same clock cycle, the event bit ends up set.
- R7: `cpu_irq` is the registered OR of (events AND enable) and (levels AND enable AND 0x3FF00000). An enabled level-type line raises it on the 3rd rising edge after the line rises and drops it on the 3rd rising edge after the line falls. A disabled source never raises it.
- R8: Writes to offsets 0x20 and 0x2C have no effect. Reads of offset 0x28 return 0. Reads of any unmapped or misaligned offset return 0, and writes to such offsets change nothing.
- R9: When `rd_en` is sampled high, `rdata` holds the addressed value after that clock edge, and `rd_valid` is high for exactly that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 32 | Asynchronous interrupt request lines |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte address of the register access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| cpu_irq | output | 1 | Registered interrupt request to the processor |

## Verification
A corrupted event latch shows up at the ports in one of two ways. It can appear as a wrong bit in the next event read, or as `cpu_irq` going wrong one cycle after the latch does, as long as the bit is enabled. A synchroniser or edge-detector fault shifts the exact edge count at which `cpu_irq` rises, so the bench samples the request one edge before and one edge after the cycle the requirements predict. A wrong enable bit or level-group decode keeps the request silent, or raises it, for an entire pulse on a single source. For that reason each of the 32 sources is driven and checked on its own.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned NSRC = 32;
  localparam int unsigned AW   = 8;
  localparam int unsigned DW   = 32;

  localparam logic [AW-1:0] OFS_EVENT = 8'h20;
  localparam logic [AW-1:0] OFS_MASK  = 8'h24;
  localparam logic [AW-1:0] OFS_CLEAR = 8'h28;
  localparam logic [AW-1:0] OFS_LEVEL = 8'h2C;

  localparam logic [NSRC-1:0] LEVEL_GROUP = 32'h3FF0_0000;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_EVENT,
    SEL_MASK,
    SEL_CLEAR,
    SEL_LEVEL
  } reg_sel_e;
endpackage

// File: rtl/irq_sync_edge.sv
module irq_sync_edge #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] line_i,
  output logic [WIDTH-1:0] level_o,
  output logic [WIDTH-1:0] rise_o
);
  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[g] <= '0;
          else     stage_q[g] <= line_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[g] <= '0;
          else     stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= stage_q[STAGES-1];
  end

  assign level_o = stage_q[STAGES-1];
  assign rise_o  = stage_q[STAGES-1] & ~prev_q;

  // R2: a detected rise is a single-cycle pulse per bit
  p_rise_single_r2: assert property (@(posedge clk) disable iff (rst)
    ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/irq_event_bank.sv
module irq_event_bank #(
  parameter int unsigned    WIDTH = 32,
  parameter logic [WIDTH-1:0] LVL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] rise_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] ev_q
);
  logic [WIDTH-1:0] set_v;
  logic [WIDTH-1:0] ev_d;

  assign set_v = rise_i & ~LVL;

  always_comb begin
    ev_d = (ev_q & ~clr_i) | set_v;
  end

  always_ff @(posedge clk) begin
    if (rst) ev_q <= '0;
    else     ev_q <= ev_d;
  end

  // R6: a new edge always lands, even under a simultaneous clear
  p_set_wins_r6: assert property (@(posedge clk) disable iff (rst)
    ((ev_q & $past(set_v)) == $past(set_v)));

  // R5: a cleared bit without a coincident edge reads back zero
  p_clear_r5: assert property (@(posedge clk) disable iff (rst)
    ((ev_q & $past(clr_i & ~set_v)) == '0));
endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
  import irq_pkg::*;
#(
  parameter int unsigned      WIDTH = 32,
  parameter logic [WIDTH-1:0] LVL   = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [WIDTH-1:0] ev_q,
  input  logic [WIDTH-1:0] lvl_q,
  output logic [WIDTH-1:0] mask_q,
  output logic [WIDTH-1:0] clr_v,
  output logic [WIDTH-1:0] rdata,
  output logic             rd_valid
);
  reg_sel_e         sel;
  logic [WIDTH-1:0] rd_mux;

  always_comb begin
    unique case (addr)
      OFS_EVENT: sel = SEL_EVENT;
      OFS_MASK:  sel = SEL_MASK;
      OFS_CLEAR: sel = SEL_CLEAR;
      OFS_LEVEL: sel = SEL_LEVEL;
      default:   sel = SEL_NONE;
    endcase
  end

  assign clr_v = (wr_en && sel == SEL_CLEAR) ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst)                         mask_q <= '0;
    else if (wr_en && sel == SEL_MASK) mask_q <= wdata;
  end

  always_comb begin
    case (sel)
      SEL_EVENT: rd_mux = ev_q & ~LVL;
      SEL_MASK:  rd_mux = mask_q;
      SEL_LEVEL: rd_mux = lvl_q;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rdata <= rd_mux;
    end
  end

  // R4: an enable write is visible on the following cycle
  p_mask_wr_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFS_MASK) |=> (mask_q == $past(wdata)));

  // R8: writes elsewhere never disturb the enable register
  p_unmapped_no_effect_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr != OFS_MASK) |=> $stable(mask_q));

  // R9: read valid strobe follows the request by exactly one cycle
  p_rd_valid_r9: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
  p_rd_valid_once_r9: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);
endmodule

// File: rtl/mixed_irq_ctrl.sv
module mixed_irq_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned      N_SRC       = NSRC,
  parameter int unsigned      SYNC_STAGES = 2,
  parameter logic [N_SRC-1:0] LVL_BITS    = LEVEL_GROUP
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] src_i,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [AW-1:0]    addr,
  input  logic [N_SRC-1:0] wdata,
  output logic [N_SRC-1:0] rdata,
  output logic             rd_valid,
  output logic             cpu_irq
);
  logic [N_SRC-1:0] lvl_q;
  logic [N_SRC-1:0] rise_v;
  logic [N_SRC-1:0] ev_q;
  logic [N_SRC-1:0] mask_q;
  logic [N_SRC-1:0] clr_v;
  logic [N_SRC-1:0] pend_v;

  irq_sync_edge #(.WIDTH(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .line_i(src_i), .level_o(lvl_q), .rise_o(rise_v)
  );

  irq_event_bank #(.WIDTH(N_SRC), .LVL(LVL_BITS)) u_events (
    .clk(clk), .rst(rst), .rise_i(rise_v), .clr_i(clr_v), .ev_q(ev_q)
  );

  irq_regfile #(.WIDTH(N_SRC), .LVL(LVL_BITS)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .ev_q(ev_q), .lvl_q(lvl_q), .mask_q(mask_q),
    .clr_v(clr_v), .rdata(rdata), .rd_valid(rd_valid)
  );

  assign pend_v = ((ev_q & ~LVL_BITS) | (lvl_q & LVL_BITS)) & mask_q;

  always_ff @(posedge clk) begin
    if (rst) cpu_irq <= 1'b0;
    else     cpu_irq <= |pend_v;
  end

  // R7: an enabled latched edge event keeps the request high until cleared
  p_irq_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (((ev_q & mask_q & ~LVL_BITS) != '0) && clr_v == '0 && $stable(mask_q))
      |=> cpu_irq);

  // R7: with nothing enabled the request stays low
  p_irq_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '0) |=> !cpu_irq);
endmodule

// File: tb/test_mixed_irq_ctrl.sv
module test_mixed_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] src_i;
  logic        wr_en, rd_en;
  logic [7:0]  addr;
  logic [31:0] wdata, rdata;
  logic        rd_valid, cpu_irq;
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;

  localparam logic [31:0] LVLM = 32'h3FF0_0000;

  always #5 clk = ~clk;

  mixed_irq_ctrl i_mixed_irq_ctrl (
    .clk(clk), .rst(rst), .src_i(src_i), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid),
    .cpu_irq(cpu_irq)
  );

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%08h exp=%08h", req, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
    check("R9 rd_valid", {31'b0, rd_valid}, 32'd1);
  endtask

  initial begin
    logic [31:0] v;
    rst = 1'b1; src_i = '0; wr_en = 0; rd_en = 0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    check("R1 irq", {31'b0, cpu_irq}, 32'd0);
    rd(8'h24, v); check("R1 mask", v, 32'd0);
    rd(8'h20, v); check("R1 event", v, 32'd0);
    @(negedge clk); check("R9 rd_valid low", {31'b0, rd_valid}, 32'd0);

    wr(8'h24, 32'hA5C3_0F96); rd(8'h24, v); check("R4 mask", v, 32'hA5C3_0F96);
    wr(8'h24, 32'h5A3C_F069); rd(8'h24, v); check("R4 mask", v, 32'h5A3C_F069);

    // Sweep every source on its own: latency, latching, levels, clear
    for (int i = 0; i < 32; i++) begin
      logic [31:0] b;
      bit lv;
      int lat;
      b = 32'd1 << i;
      lv = (LVLM[i] == 1'b1);
      lat = lv ? 3 : 4;
      wr(8'h24, b);
      @(negedge clk); src_i = b;
      for (int k = 1; k < lat; k++) @(negedge clk);
      check(lv ? "R7 level latency early" : "R2 edge latency early",
            {31'b0, cpu_irq}, 32'd0);
      @(negedge clk);
      check(lv ? "R7 level latency" : "R2 edge latency",
            {31'b0, cpu_irq}, 32'd1);
      rd(8'h2C, v); check("R3 levels live", v, b);
      src_i = '0;
      repeat (4) @(negedge clk);
      check(lv ? "R7 level drop" : "R2 edge sticky irq",
            {31'b0, cpu_irq}, lv ? 32'd0 : 32'd1);
      rd(8'h20, v); check(lv ? "R3 event level bits zero" : "R2 event latched",
                          v, lv ? 32'd0 : b);
      rd(8'h2C, v); check("R3 levels low", v, 32'd0);
      wr(8'h28, b);
      rd(8'h20, v); check("R5 event cleared", v, 32'd0);
      check("R5 irq after clear", {31'b0, cpu_irq}, 32'd0);
    end

    // Disabled source never raises the request
    wr(8'h24, 32'h0);
    @(negedge clk); src_i = 32'h0000_0081;
    repeat (5) @(negedge clk);
    check("R7 disabled irq", {31'b0, cpu_irq}, 32'd0);
    rd(8'h20, v); check("R2 event w/o enable", v, 32'h0000_0081);
    src_i = '0;
    // Clear with zeros leaves other bits
    wr(8'h28, 32'h0000_0080);
    rd(8'h20, v); check("R5 partial clear", v, 32'h0000_0001);
    // Writes to event / levels ignored
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h20, v); check("R8 event write ignored", v, 32'h0000_0001);
    wr(8'h2C, 32'hFFFF_FFFF);
    rd(8'h2C, v); check("R8 levels write ignored", v, 32'h0);
    wr(8'h28, 32'hFFFF_FFFF);

    // Same-cycle edge and clear: the edge wins
    @(negedge clk); src_i = 32'h0000_0008;
    @(negedge clk);
    @(negedge clk);
    wr_en = 1'b1; addr = 8'h28; wdata = 32'h0000_0008;
    @(negedge clk); wr_en = 1'b0;
    rd(8'h20, v); check("R6 set wins", v, 32'h0000_0008);
    src_i = '0;

    // Clear register, unmapped and misaligned reads; unmapped write
    rd(8'h28, v); check("R8 clear reads zero", v, 32'h0);
    rd(8'h30, v); check("R8 unmapped read", v, 32'h0);
    rd(8'h22, v); check("R8 misaligned read", v, 32'h0);
    wr(8'h24, 32'h1234_5678);
    wr(8'h30, 32'hFFFF_FFFF);
    wr(8'h25, 32'h0);
    rd(8'h24, v); check("R8 unmapped write no effect", v, 32'h1234_5678);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    done = 1;
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog got=timeout exp=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule